// File: doc/BRIEF.md
# Pattern-Expansion Pixel Writer

The block turns one host write of an 8-bit monochrome pattern into eight pixel writes on a byte-addressed video memory port. It scans the pattern from its top bit down. A set bit writes the foreground colour. A clear bit does one of two things, chosen per request: in transparent mode it writes nothing, and in opaque mode it writes the background colour. Each request also selects the pixel size, either one byte or two bytes.

The request's offset, pattern, mode, pixel size, colours and aperture mask are captured when the request is accepted. The unit then issues one pixel step per clock for eight clocks and pulses done. The aperture mask is applied to every pixel address separately, so a run that crosses the top of the aperture wraps back to its base. A run never runs past the aperture.

Top module: `cexp_writer`

## Requirements
- R1: After reset, busy_o, done_o and mem_we_o are low, and mem_be_o is 0.
- R2: A request is accepted only when req_i is high at a rising edge while busy_o is low. busy_o is then high for exactly eight cycles, one pixel step per cycle. req_i is ignored while busy_o is high.
- R3: Pixel step x (x = 0..7) is driven by pattern bit 7-x, so the most significant bit comes first.
- R4: A set pattern bit gives mem_we_o = 1 with the foreground colour on the data bus.
- R5: A clear bit with opaque_i = 1 writes the background colour. A clear bit with opaque_i = 0 gives mem_we_o = 0 and mem_be_o = 0 for that step.
- R6: With wide_i = 0, the write for step x goes to (offset + x) & mask. It has mem_be_o = 2'b01, mem_wdata_o[7:0] = low colour byte and mem_wdata_o[15:8] = 0.
- R7: With wide_i = 1, the write for step x goes to ((offset + 2x) & mask) with bit 0 cleared. It has mem_be_o = 2'b11 and mem_wdata_o = {high colour byte, low colour byte}. Byte lane 0 goes to the address itself and lane 1 goes to the address plus 1.
- R8: Changes to any request input after acceptance do not affect the run in progress.
- R9: Every write address has no bit set outside the captured aperture mask, including runs that wrap past the top of the aperture.
- R10: done_o is high for exactly one cycle, in the cycle right after the eighth step. busy_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Expansion request |
| offset_i | input | AW | Byte offset of the first pixel |
| pattern_i | input | 8 | Monochrome pattern, MSB first |
| opaque_i | input | 1 | 1: clear bits write the background colour; 0: clear bits are skipped |
| wide_i | input | 1 | 1: 16-bit pixels; 0: 8-bit pixels |
| fg_lo_i | input | 8 | Foreground colour, low byte |
| fg_hi_i | input | 8 | Foreground colour, high byte |
| bg_lo_i | input | 8 | Background colour, low byte |
| bg_hi_i | input | 8 | Background colour, high byte |
| addr_mask_i | input | AW | Aperture address mask |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory byte address |
| mem_be_o | output | 2 | Byte-lane enables |
| mem_wdata_o | output | 16 | Write data, lane 0 in bits 7:0 |

## Verification
The assertions assume that the aperture mask is a contiguous run of low-order ones, so masking an address is the same as taking it modulo the aperture. They also assume that the memory port accepts one write every cycle, with no stall. The bench keeps to these assumptions: it uses only low-order masks of 0x3FF and all ones, and it never applies back-pressure. Within that, it sweeps all 256 patterns across both modes and both pixel sizes. The offsets carry bits above the mask and sit near the top of the aperture. During every run the bench holds req_i high and changes every request input.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } colour_t;
endpackage

// File: rtl/cexp_seq.sv
module cexp_seq #(
  parameter int NPIX = 8,
  localparam int IW = $clog2(NPIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      idx_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (idx_o == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          idx_o  <= '0;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end else if (start_i) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
      end
    end
  end

  // one step per cycle while running
  p_step_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> idx_o == IW'($past(idx_o) + 1'b1));
endmodule

// File: rtl/cexp_addr.sv
module cexp_addr #(
  parameter int AW = 22,
  parameter int IW = 3
) (
  input  logic [AW-1:0] offset_i,
  input  logic [AW-1:0] mask_i,
  input  logic [IW-1:0] idx_i,
  input  logic          wide_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] step;
  logic [AW-1:0] sum;

  always_comb begin
    step = wide_i ? AW'({idx_i, 1'b0}) : AW'(idx_i);
    sum  = offset_i + step;
    // re-mask every pixel; wide pixels are word aligned
    addr_o = sum & mask_i & ~AW'(wide_i);
  end
endmodule

// File: rtl/cexp_pix.sv
module cexp_pix
  import cexp_pkg::*;
(
  input  logic        active_i,
  input  logic        bit_i,
  input  logic        opaque_i,
  input  logic        wide_i,
  input  colour_t     fg_i,
  input  colour_t     bg_i,
  output logic        we_o,
  output logic [1:0]  be_o,
  output logic [15:0] wdata_o
);
  colour_t col;

  always_comb begin
    col  = bit_i ? fg_i : bg_i;
    we_o = active_i & (bit_i | opaque_i);
    be_o = we_o ? {wide_i, 1'b1} : 2'b00;
    wdata_o = wide_i ? {col.hi, col.lo} : {8'h00, col.lo};
  end
endmodule

// File: rtl/cexp_writer.sv
module cexp_writer
  import cexp_pkg::*;
#(
  parameter int AW   = 22,
  parameter int NPIX = 8,
  localparam int IW  = $clog2(NPIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] offset_i,
  input  logic [7:0]    pattern_i,
  input  logic          opaque_i,
  input  logic          wide_i,
  input  logic [7:0]    fg_lo_i,
  input  logic [7:0]    fg_hi_i,
  input  logic [7:0]    bg_lo_i,
  input  logic [7:0]    bg_hi_i,
  input  logic [AW-1:0] addr_mask_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_be_o,
  output logic [15:0]   mem_wdata_o
);
  logic          start;
  logic [IW-1:0] idx;
  logic [AW-1:0] off_q, mask_q;
  logic [7:0]    pat_q;
  logic          opaque_q, wide_q;
  colour_t       fg_q, bg_q;

  assign start = req_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q    <= '0;
      mask_q   <= '0;
      pat_q    <= '0;
      opaque_q <= 1'b0;
      wide_q   <= 1'b0;
      fg_q     <= '0;
      bg_q     <= '0;
    end else if (start) begin
      off_q    <= offset_i;
      mask_q   <= addr_mask_i;
      pat_q    <= pattern_i;
      opaque_q <= opaque_i;
      wide_q   <= wide_i;
      fg_q     <= '{hi: fg_hi_i, lo: fg_lo_i};
      bg_q     <= '{hi: bg_hi_i, lo: bg_lo_i};
    end else if (busy_o) begin
      pat_q <= {pat_q[6:0], 1'b0};  // msb first
    end
  end

  cexp_seq #(.NPIX(NPIX)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .idx_o   (idx)
  );

  cexp_addr #(.AW(AW), .IW(IW)) u_addr (
    .offset_i (off_q),
    .mask_i   (mask_q),
    .idx_i    (idx),
    .wide_i   (wide_q),
    .addr_o   (mem_addr_o)
  );

  cexp_pix u_pix (
    .active_i (busy_o),
    .bit_i    (pat_q[7]),
    .opaque_i (opaque_q),
    .wide_i   (wide_q),
    .fg_i     (fg_q),
    .bg_i     (bg_q),
    .we_o     (mem_we_o),
    .be_o     (mem_be_o),
    .wdata_o  (mem_wdata_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && mem_be_o == 2'b00));
  p_in_aperture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o & ~mask_q) == '0);
  p_wide_even_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_be_o == 2'b11) |-> !mem_addr_o[0]);
  p_done_after_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/cexp_writer_bench.sv
module cexp_writer_bench;
  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] offset = '0;
  logic [7:0]    pattern = '0;
  logic          opaque = 1'b0;
  logic          wide = 1'b0;
  logic [7:0]    fg_lo = '0, fg_hi = '0, bg_lo = '0, bg_hi = '0;
  logic [AW-1:0] mask = '0;
  logic          busy, done, we;
  logic [AW-1:0] addr;
  logic [1:0]    be;
  logic [15:0]   wdata;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cexp_writer #(.AW(AW)) u_cexp_writer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .offset_i(offset),
    .pattern_i(pattern), .opaque_i(opaque), .wide_i(wide),
    .fg_lo_i(fg_lo), .fg_hi_i(fg_hi), .bg_lo_i(bg_lo), .bg_hi_i(bg_hi),
    .addr_mask_i(mask), .busy_o(busy), .done_o(done), .mem_we_o(we),
    .mem_addr_o(addr), .mem_be_o(be), .mem_wdata_o(wdata)
  );

  task automatic chk(input string req_tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] o, input logic [7:0] p, input logic op,
                     input logic wd, input logic [AW-1:0] m,
                     input logic [7:0] fl, input logic [7:0] fh,
                     input logic [7:0] bl, input logic [7:0] bh);
    @(negedge clk);
    req = 1'b1; offset = o; pattern = p; opaque = op; wide = wd; mask = m;
    fg_lo = fl; fg_hi = fh; bg_lo = bl; bg_hi = bh;
    for (int x = 0; x < 8; x++) begin
      logic bitv, expwe;
      logic [AW-1:0] ea;
      logic [7:0] cl, ch;
      @(negedge clk);
      // R2/R8: keep requesting with scrambled inputs during the run
      offset = ~o; pattern = ~p; opaque = ~op; wide = ~wd; mask = ~m;
      fg_lo = ~fl; fg_hi = ~fh; bg_lo = ~bl; bg_hi = ~bh;
      bitv  = p[7-x];                              // R3
      expwe = bitv | op;                           // R4 R5
      cl = bitv ? fl : bl;
      ch = bitv ? fh : bh;
      chk("R2 busy", busy, 1);
      chk("R10 done low in run", done, 0);
      chk("R5 we", we, expwe);
      if (expwe) begin
        if (wd) begin
          ea = (o + AW'(2 * x)) & m & ~AW'(1);     // R7
          chk("R7 addr", addr, ea);
          chk("R7 be", be, 2'b11);
          chk("R7 data", wdata, {ch, cl});
        end else begin
          ea = (o + AW'(x)) & m;                   // R6
          chk("R6 addr", addr, ea);
          chk("R6 be", be, 2'b01);
          chk("R6 data", wdata, {8'h00, cl});
        end
        chk("R9 aperture", addr & ~m, 0);
      end else begin
        chk("R5 transparent be", be, 0);
      end
    end
    @(negedge clk);
    req = 1'b0;
    chk("R10 done", done, 1);
    chk("R10 busy low", busy, 0);
    chk("R10 we low", we, 0);
    @(negedge clk);
    chk("R10 done single", done, 0);
    chk("R2 stays idle", busy, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 we", we, 0);
    chk("R1 be", be, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);

    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 256; p++) begin
        run(AW'(22'h155000 ^ (p * 13 + c * 3)), 8'(p), c[0], c[1], 22'h0003FF,
            8'(p ^ 8'hA5), 8'(p + 3), 8'(~p), 8'(p ^ 8'h3C));
      end
    end
    // R9: wrap at the top of a full-width aperture
    run(22'h3FFFFC, 8'hFF, 1'b0, 1'b1, 22'h3FFFFF, 8'h11, 8'h22, 8'h33, 8'h44);
    run(22'h3FFFFB, 8'h5A, 1'b1, 1'b0, 22'h3FFFFF, 8'h66, 8'h77, 8'h88, 8'h99);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule